// File: doc/BRIEF.md
# Width-Aware Register Transfer Unit

This block holds the architectural registers of a small processor core and executes the operations that move data between those registers. The registers are a 16-bit accumulator, two index registers, a 16-bit direct page base and a 16-bit stack pointer. The accumulator is made of a visible low byte and a hidden high byte. A status byte and a separate emulation bit complete the set. Two status bits select 8-bit or 16-bit width: one for the accumulator and one for the index registers. In emulation the core behaves like its 8-bit predecessor. Both widths are then pinned to 8 bits and the stack is confined to one fixed page.

Each cycle with `op_valid` high executes one operation from `op_code`. The operations are register-to-register copies, the accumulator byte swap, the carry/emulation exchange, and the clear-mask and set-mask status edits. Load operations write a value from `op_data`, which is the result returned by memory or the ALU, into one register at that register's current width. The width of a copy is the width of its destination. Copies that report flags update the negative and zero bits from the value that actually lands in the destination.

Top module: `xfer_regfile`

## Requirements
- R1: After reset, acc=0x0000, xr=0x0000, yr=0x0000, dpr=0x0000, spr=0x01FF, psw=0x34 and emu=1. Status bit positions are n=7, v=6, m=5 (8-bit accumulator when 1), x=4 (8-bit index when 1), d=3, i=2, z=1, c=0.
- R2: Copies whose destination is an index register use the x width. The codes are 1 (acc to xr), 2 (acc to yr), 5 (spr to xr), 7 (xr to yr) and 8 (yr to xr). With 16-bit index registers all 16 source bits are copied, so the hidden accumulator byte becomes the index high byte even when m=1. With 8-bit index registers the low byte is copied and the high byte is 0.
- R3: Copies into the accumulator use the m width. The codes are 3 (xr to acc) and 4 (yr to acc). With m=1 only the low byte changes and the hidden byte keeps its value. With m=0 all 16 bits are written, and the high byte is 0 when the index registers are 8-bit.
- R4: The copies with codes 1, 2, 3, 4, 5, 7, 8, 9, 10 and 12 set n from the most significant bit of the copied value at the destination width. They set z when that value is zero. The other status bits are left unchanged.
- R5: Code 6 copies xr into spr; when x=1 this makes the stack high byte 0. In emulation the stack high byte is always 0x01. Codes 6 and 11 change no status bit.
- R6: Codes 9 (acc to dpr), 10 (dpr to acc), 11 (acc to spr) and 12 (spr to acc) always move 16 bits, whatever m is.
- R7: Code 13 swaps the two accumulator bytes whatever m is. It sets n from the new bit 7 and sets z when the new low byte is zero.
- R8: Code 15 clears every status bit whose op_imm bit is 1. Code 16 sets every status bit whose op_imm bit is 1. Status bits whose op_imm bit is 0 are unchanged.
- R9: Code 14 exchanges c and emu. When emu becomes 1, m and x become 1, the index high bytes become 0 and the stack high byte becomes 0x01.
- R10: Whenever x is 1, the high bytes of xr and yr are 0.
- R11: While emu=1, m and x read as 1, and codes 15 and 16 cannot change them.
- R12: Codes 17 to 21 load op_data into acc, xr, yr, dpr and spr in that order, at the destination's width and with the emulation stack page. Loads change no status bit.
- R13: A cycle with op_valid low, or with code 0 or any code from 22 to 31, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute op_code this cycle |
| op_code | input | 5 | Operation select |
| op_imm | input | 8 | Status mask for codes 15 and 16 |
| op_data | input | 16 | Load value for codes 17 to 21 |
| acc | output | 16 | Accumulator; the high byte is the hidden byte |
| xr | output | 16 | X index register |
| yr | output | 16 | Y index register |
| dpr | output | 16 | Direct page base |
| spr | output | 16 | Stack pointer |
| psw | output | 8 | Status byte |
| emu | output | 1 | Emulation bit |

## Verification
The assertions check the mode invariants on every cycle: in emulation m and x are pinned and the stack page is fixed, and while x=1 the index high bytes are zero. They also check the mask edits, the byte swap, the flag-free stack load and the idle hold over each executed operation. Only the bench's scenarios can show the width rules for each copy. These are whether the hidden byte survives or moves into an index register, and which byte n and z come from. The bench sweeps every transfer over all four width combinations and over emulation, using value patterns that place set bits at 7, 15 and in each byte.

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter logic [7:0]  EMU_PAGE  = 8'h01,
  parameter logic [15:0] SP_RESET  = 16'h01FF,
  parameter logic [7:0]  PSW_RESET = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [4:0]  op_code,
  input  logic [7:0]  op_imm,
  input  logic [15:0] op_data,
  output logic [15:0] acc,
  output logic [15:0] xr,
  output logic [15:0] yr,
  output logic [15:0] dpr,
  output logic [15:0] spr,
  output logic [7:0]  psw,
  output logic        emu
);
  localparam logic [4:0] OP_A2X = 5'd1,  OP_A2Y = 5'd2,  OP_X2A = 5'd3,  OP_Y2A = 5'd4;
  localparam logic [4:0] OP_S2X = 5'd5,  OP_X2S = 5'd6,  OP_X2Y = 5'd7,  OP_Y2X = 5'd8;
  localparam logic [4:0] OP_C2D = 5'd9,  OP_D2C = 5'd10, OP_C2S = 5'd11, OP_S2C = 5'd12;
  localparam logic [4:0] OP_SWB = 5'd13, OP_CXE = 5'd14, OP_CLR = 5'd15, OP_SET = 5'd16;
  localparam logic [4:0] OP_LDA = 5'd17, OP_LDX = 5'd18, OP_LDY = 5'd19, OP_LDD = 5'd20;
  localparam logic [4:0] OP_LDS = 5'd21;
  localparam int BN = 7, BM = 5, BX = 4, BZ = 1, BC = 0;

  logic [15:0] a_n, x_n, y_n, d_n, s_n, fv;
  logic [7:0]  p_n;
  logic        e_n, fl_upd, f16;

  wire m8 = psw[BM];
  wire x8 = psw[BX];

  function automatic logic [15:0] to_idx(input logic [15:0] v, input logic narrow);
    return narrow ? {8'h00, v[7:0]} : v;
  endfunction

  always_comb begin
    a_n = acc; x_n = xr; y_n = yr; d_n = dpr; s_n = spr; p_n = psw; e_n = emu;
    fl_upd = 1'b0; f16 = 1'b0; fv = '0;
    if (op_valid) begin
      case (op_code)
        OP_A2X: begin x_n = to_idx(acc, x8); fv = x_n; f16 = !x8; fl_upd = 1'b1; end
        OP_A2Y: begin y_n = to_idx(acc, x8); fv = y_n; f16 = !x8; fl_upd = 1'b1; end
        OP_S2X: begin x_n = to_idx(spr, x8); fv = x_n; f16 = !x8; fl_upd = 1'b1; end
        OP_X2Y: begin y_n = to_idx(xr, x8);  fv = y_n; f16 = !x8; fl_upd = 1'b1; end
        OP_Y2X: begin x_n = to_idx(yr, x8);  fv = x_n; f16 = !x8; fl_upd = 1'b1; end
        OP_X2A: begin
          a_n = m8 ? {acc[15:8], xr[7:0]} : xr;
          fv = a_n; f16 = !m8; fl_upd = 1'b1;
        end
        OP_Y2A: begin
          a_n = m8 ? {acc[15:8], yr[7:0]} : yr;
          fv = a_n; f16 = !m8; fl_upd = 1'b1;
        end
        OP_X2S: s_n = xr;
        OP_C2D: begin d_n = acc; fv = acc; f16 = 1'b1; fl_upd = 1'b1; end
        OP_D2C: begin a_n = dpr; fv = dpr; f16 = 1'b1; fl_upd = 1'b1; end
        OP_C2S: s_n = acc;
        OP_S2C: begin a_n = spr; fv = spr; f16 = 1'b1; fl_upd = 1'b1; end
        OP_SWB: begin a_n = {acc[7:0], acc[15:8]}; fv = a_n; fl_upd = 1'b1; end
        OP_CXE: begin e_n = psw[BC]; p_n[BC] = emu; end
        OP_CLR: p_n = psw & ~op_imm;
        OP_SET: p_n = psw | op_imm;
        OP_LDA: a_n = m8 ? {acc[15:8], op_data[7:0]} : op_data;
        OP_LDX: x_n = to_idx(op_data, x8);
        OP_LDY: y_n = to_idx(op_data, x8);
        OP_LDD: d_n = op_data;
        OP_LDS: s_n = op_data;
        default: ;
      endcase
    end
    if (fl_upd) begin
      p_n[BN] = f16 ? fv[15] : fv[7];
      p_n[BZ] = f16 ? (fv == 16'h0000) : (fv[7:0] == 8'h00);
    end
    if (e_n) begin
      p_n[BM] = 1'b1;
      p_n[BX] = 1'b1;
      s_n[15:8] = EMU_PAGE;
    end
    if (p_n[BX]) begin
      x_n[15:8] = 8'h00;
      y_n[15:8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; xr <= '0; yr <= '0; dpr <= '0;
      spr <= SP_RESET; psw <= PSW_RESET; emu <= 1'b1;
    end else begin
      acc <= a_n; xr <= x_n; yr <= y_n; dpr <= d_n;
      spr <= s_n; psw <= p_n; emu <= e_n;
    end
  end
endmodule

// File: rtl/xfer_regfile_chk.sv
module xfer_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [4:0]  op_code,
  input logic [7:0]  op_imm,
  input logic [15:0] acc,
  input logic [15:0] xr,
  input logic [15:0] yr,
  input logic [15:0] dpr,
  input logic [15:0] spr,
  input logic [7:0]  psw,
  input logic        emu
);
  p_emu_widths_r11: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (psw[5] && psw[4]));

  p_idx_high_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psw[4] |-> (xr[15:8] == 8'h00 && yr[15:8] == 8'h00));

  p_emu_stack_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (spr[15:8] == 8'h01));

  p_swap_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd13) |=> (acc == {$past(acc[7:0]), $past(acc[15:8])}));

  p_stack_load_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd11) |=> $stable(psw));

  p_clear_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd15) |=>
      ((psw & $past(op_imm) & ($past(emu) ? 8'hCF : 8'hFF)) == 8'h00));

  p_set_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd16) |=> ((psw & $past(op_imm)) == $past(op_imm)));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc) && $stable(xr) && $stable(yr) && $stable(dpr)
                   && $stable(spr) && $stable(psw) && $stable(emu)));
endmodule

bind xfer_regfile xfer_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_imm(op_imm),
  .acc(acc), .xr(xr), .yr(yr), .dpr(dpr), .spr(spr), .psw(psw), .emu(emu)
);

// File: tb/sim_xfer_regfile.sv
module sim_xfer_regfile;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] op_imm = '0;
  logic [15:0] op_data = '0;
  logic [15:0] acc, xr, yr, dpr, spr;
  logic [7:0] psw;
  logic emu;
  int checks = 0, errors = 0;
  logic [15:0] m_a, m_x, m_y, m_d, m_s;
  logic [7:0] m_p;
  logic m_e;

  always #5 clk = ~clk;

  xfer_regfile u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_imm(op_imm), .op_data(op_data), .acc(acc), .xr(xr), .yr(yr), .dpr(dpr),
    .spr(spr), .psw(psw), .emu(emu));

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic string req_of(input logic [4:0] op, input logic e);
    case (op)
      5'd1, 5'd2, 5'd5, 5'd7, 5'd8: return "R2";
      5'd3, 5'd4:                   return "R3";
      5'd6:                         return "R5";
      5'd9, 5'd10, 5'd11, 5'd12:    return "R6";
      5'd13:                        return "R7";
      5'd14:                        return "R9";
      5'd15, 5'd16:                 return e ? "R11" : "R8";
      5'd17, 5'd18, 5'd19, 5'd20, 5'd21: return "R12";
      default:                      return "R13";
    endcase
  endfunction

  task automatic model(input logic v, input logic [4:0] op, input logic [7:0] im,
                       input logic [15:0] dv);
    logic [15:0] val;
    logic wide, setf, nm8, nx8;
    setf = 1'b0; wide = 1'b0; val = '0;
    nm8 = m_p[5]; nx8 = m_p[4];
    if (v) begin
      case (op)
        5'd1: begin m_x = nx8 ? {8'h00, m_a[7:0]} : m_a; val = m_x; wide = !nx8; setf = 1; end
        5'd2: begin m_y = nx8 ? {8'h00, m_a[7:0]} : m_a; val = m_y; wide = !nx8; setf = 1; end
        5'd5: begin m_x = nx8 ? {8'h00, m_s[7:0]} : m_s; val = m_x; wide = !nx8; setf = 1; end
        5'd7: begin m_y = m_x; val = m_y; wide = !nx8; setf = 1; end
        5'd8: begin m_x = m_y; val = m_x; wide = !nx8; setf = 1; end
        5'd3: begin m_a = nm8 ? {m_a[15:8], m_x[7:0]} : m_x; val = m_a; wide = !nm8; setf = 1; end
        5'd4: begin m_a = nm8 ? {m_a[15:8], m_y[7:0]} : m_y; val = m_a; wide = !nm8; setf = 1; end
        5'd6: m_s = m_e ? {8'h01, m_x[7:0]} : m_x;
        5'd9: begin m_d = m_a; val = m_a; wide = 1; setf = 1; end
        5'd10: begin m_a = m_d; val = m_d; wide = 1; setf = 1; end
        5'd11: m_s = m_e ? {8'h01, m_a[7:0]} : m_a;
        5'd12: begin m_a = m_s; val = m_s; wide = 1; setf = 1; end
        5'd13: begin m_a = {m_a[7:0], m_a[15:8]}; val = m_a; setf = 1; end
        5'd14: begin
          logic t; t = m_e; m_e = m_p[0]; m_p[0] = t;
          if (m_e) begin m_p[5] = 1; m_p[4] = 1; m_s[15:8] = 8'h01; m_x[15:8] = 0; m_y[15:8] = 0; end
        end
        5'd15: begin m_p = m_p & ~im; if (m_e) m_p[5:4] = 2'b11; end
        5'd16: begin
          m_p = m_p | im; if (m_e) m_p[5:4] = 2'b11;
          if (m_p[4]) begin m_x[15:8] = 0; m_y[15:8] = 0; end
        end
        5'd17: m_a = nm8 ? {m_a[15:8], dv[7:0]} : dv;
        5'd18: m_x = nx8 ? {8'h00, dv[7:0]} : dv;
        5'd19: m_y = nx8 ? {8'h00, dv[7:0]} : dv;
        5'd20: m_d = dv;
        5'd21: m_s = m_e ? {8'h01, dv[7:0]} : dv;
        default: ;
      endcase
    end
    if (setf) begin
      m_p[7] = wide ? val[15] : val[7];
      m_p[1] = wide ? (val == 0) : (val[7:0] == 0);
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({acc, xr, yr, dpr, spr, psw, emu} !== {m_a, m_x, m_y, m_d, m_s, m_p, m_e}) begin
      errors++;
      $display("FAIL %s: actual a=%h x=%h y=%h d=%h s=%h p=%h e=%b expected a=%h x=%h y=%h d=%h s=%h p=%h e=%b",
        tag, acc, xr, yr, dpr, spr, psw, emu, m_a, m_x, m_y, m_d, m_s, m_p, m_e);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] op, input logic [7:0] im,
                      input logic [15:0] dv);
    logic olde;
    string tag;
    olde = m_e;
    @(negedge clk);
    op_valid = v; op_code = op; op_imm = im; op_data = dv;
    @(posedge clk);
    #1 op_valid = 1'b0;
    model(v, op, im, dv);
    tag = v ? req_of(op, olde) : "R13";
    if (v && (op inside {5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12})
        && {acc, xr, yr, dpr, spr, emu} === {m_a, m_x, m_y, m_d, m_s, m_e})
      tag = "R4";
    compare(tag);
  endtask

  task automatic set_mode(input logic e, input logic m8, input logic x8);
    if (m_e != e) begin
      step(1, e ? 5'd16 : 5'd15, 8'h01, 0);
      step(1, 5'd14, 0, 0);
    end
    if (!e) begin
      step(1, 5'd15, 8'h30, 0);
      step(1, 5'd16, {2'b00, m8, x8, 4'b0000}, 0);
    end
    if (m_p[4]) begin
      checks++;
      if (xr[15:8] !== 8'h00 || yr[15:8] !== 8'h00) begin
        errors++;
        $display("FAIL R10: actual xh=%h yh=%h expected 00 00", xr[15:8], yr[15:8]);
      end
    end
  endtask

  logic [15:0] pats [7] = '{16'h0000, 16'h0080, 16'h00FF, 16'h8000, 16'h7F01, 16'hFF00, 16'h1234};

  initial begin
    m_a = 0; m_x = 0; m_y = 0; m_d = 0; m_s = 16'h01FF; m_p = 8'h34; m_e = 1;
    #22 rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    for (int mode = 0; mode < 5; mode++) begin
      set_mode(mode == 4, mode[1], mode[0]);
      for (int i = 0; i < 7; i++) begin
        logic [15:0] v;
        v = pats[i];
        step(1, 5'd15, 8'h30, 0);
        step(1, 5'd17, v, v);
        step(1, 5'd18, 0, v ^ 16'hA5C3);
        step(1, 5'd19, 0, {v[7:0], v[15:8]});
        step(1, 5'd20, 0, ~v);
        step(1, 5'd21, 0, v + 16'h0101);
        set_mode(mode == 4, mode[1], mode[0]);
        for (int op = 1; op <= 13; op++) begin
          step(1, 5'(op), 0, 0);
          if (op == 3 || op == 6 || op == 9) step(1, 5'd17, 0, v ^ 16'h8001);
        end
      end
    end
    set_mode(0, 0, 0);
    for (int k = 0; k < 256; k++) begin
      step(1, 5'd16, 8'(k), 0);
      step(1, 5'd15, 8'(k ^ 8'h5A), 0);
    end
    set_mode(1, 1, 1);
    for (int k = 0; k < 256; k++) begin
      step(1, 5'd15, 8'(k), 0);
      step(1, 5'd16, 8'(~k), 0);
    end
    step(1, 5'd15, 8'h01, 0);
    step(1, 5'd14, 0, 0);
    step(1, 5'd15, 8'h30, 0);
    step(1, 5'd14, 0, 0);
    for (int c = 0; c < 32; c++) begin
      step(0, 5'(c), 8'hFF, 16'hBEEF);
      if (c == 0 || c >= 22) step(1, 5'(c), 8'hFF, 16'hBEEF);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule